// File: doc/BRIEF.md
# Reversible-Gate Carry Look-Ahead Adder

This block adds two unsigned operands and a carry-in using nothing but three-line reversible primitives. Two primitives are available: a controlled-controlled-NOT that passes its two controls and flips its target by their AND, and a variant that also replaces its second line with the XOR of the first two. The operand width is cut into 4-bit slices. In each slice, one stage forms per-bit generate and propagate terms. The look-ahead stage builds all four slice carries from two-level expansions of those terms. The sum stage then XORs each propagate term with its carry. The slices ripple their carries from one to the next.

In the expansions, the OR of mutually exclusive product terms is realised as an XOR. Multi-term products are chained through zero-initialised ancilla targets. A single parameter maps every gate in the design onto one of the two primitive kinds. The choice changes the count of gates and lines, and it changes the leftover lines that appear on the garbage bus. It never changes the arithmetic result.

Top module: `rev_cla_adder`

## Requirements
- R1: For every operand pair and carry-in, {cout_o, sum_o} equals a_i + b_i + c_i, under both gate kinds and at widths 4 and 16.
- R2: When b_i is the bitwise inverse of a_i (every bit propagates), cout_o equals c_i and every sum bit equals the inverse of c_i. The carry crosses every slice.
- R3: garb_o[WIDTH-1:0] carries the pass-through operand-A lines and always equals a_i.
- R4: With USE_PERES = 0, garb_o[2*WIDTH-1:WIDTH] carries the constant-1 control lines of the sum gates. It is all ones.
- R5: With USE_PERES = 1, garb_o[WIDTH+n] equals (a_i[n] XOR b_i[n]) AND k[n] for each n. Here k[n] is the carry into bit n, that is, bit n of a_i ^ b_i ^ sum.
- R6: At the extremes, all-ones + all-ones + 1 gives sum all ones with cout_o = 1, and zero + zero + 0 gives sum 0 with cout_o = 0.
- R7: A WIDTH = 4 build is a single look-ahead slice. It meets R1, R3, R4 and R5 over all 512 input combinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| c_i | input | 1 | Carry-in |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry-out of the top slice |
| garb_o | output | 2*WIDTH | Leftover gate lines: A echoes low, sum-gate side lines high |

## Verification
Every result is purely combinational. Sum, carry-out and both garbage halves are due in the same cycle as the operands, after zero clock edges. The bench changes the operands just after a rising edge and samples the outputs at the following falling edge. All gate chains have settled by then, and no edge falls between stimulus and sample. The 4-bit builds are swept over all 512 combinations for each gate kind. The 16-bit builds receive random vectors plus all-propagate and extreme patterns, with expected values derived from integer addition.

// File: rtl/rev_cla_adder.sv
module rev_cla_adder #(
  parameter int WIDTH     = 16,
  parameter bit USE_PERES = 1'b0
) (
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic               c_i,
  output logic [WIDTH-1:0]   sum_o,
  output logic               cout_o,
  output logic [2*WIDTH-1:0] garb_o
);
  localparam int SLICES = WIDTH / 4;

  // line order: [2] first control, [1] second line, [0] target
  function automatic logic [2:0] ccnot(input logic x, input logic y, input logic z);
    return {x, y, (x & y) ^ z};
  endfunction

  function automatic logic [2:0] peres(input logic x, input logic y, input logic z);
    return {x, x ^ y, (x & y) ^ z};
  endfunction

  function automatic logic and2(input logic x, input logic y);
    logic [2:0] t;
    t = USE_PERES ? peres(x, y, 1'b0) : ccnot(x, y, 1'b0);
    return t[0];
  endfunction

  function automatic logic xor2(input logic x, input logic y);
    logic [2:0] t;
    if (USE_PERES) begin
      t = peres(x, y, 1'b0);
      return t[1];
    end else begin
      t = ccnot(1'b1, x, y);
      return t[0];
    end
  endfunction

  logic [SLICES:0] chain;
  assign chain[0] = c_i;
  assign cout_o   = chain[SLICES];

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    logic [3:0] gen, prp, one;
    logic [4:0] cy;

    for (genvar i = 0; i < 4; i++) begin : g_pg
      localparam int N = 4 * s + i;
      if (USE_PERES) begin : g_per
        logic [2:0] o;
        assign o         = peres(a_i[N], b_i[N], 1'b0);
        assign garb_o[N] = o[2];
        assign prp[i]    = o[1];
        assign gen[i]    = o[0];
        assign one[i]    = 1'b0;
      end else begin : g_tof
        logic [2:0] o1, o2;
        assign o1        = ccnot(a_i[N], b_i[N], 1'b0);
        assign o2        = ccnot(1'b1, o1[2], o1[1]);
        assign gen[i]    = o1[0];
        assign garb_o[N] = o2[1];
        assign prp[i]    = o2[0];
        assign one[i]    = o2[2];
      end
    end

    always_comb begin
      logic acc, pr, cin;
      cin   = chain[s];
      cy    = '0;
      cy[0] = cin;
      for (int j = 1; j <= 4; j++) begin
        acc = gen[2'(j - 1)];
        for (int k = j - 2; k >= -1; k--) begin
          pr = (k >= 0) ? gen[2'(k)] : cin;
          for (int m = k + 1; m < j; m++) pr = and2(prp[2'(m)], pr);
          acc = xor2(pr, acc);
        end
        cy[3'(j)] = acc;
      end
    end

    assign chain[s+1] = cy[4];

    for (genvar i = 0; i < 4; i++) begin : g_sum
      localparam int N = 4 * s + i;
      logic [2:0] o;
      if (USE_PERES) begin : g_per
        assign o                 = peres(cy[i], prp[i], 1'b0);
        assign sum_o[N]          = o[1];
        assign garb_o[WIDTH + N] = o[0];
      end else begin : g_tof
        assign o                 = ccnot(one[i], cy[i], prp[i]);
        assign sum_o[N]          = o[0];
        assign garb_o[WIDTH + N] = o[2];
      end
    end
  end
endmodule

module rev_cla_adder_chk #(
  parameter int WIDTH     = 16,
  parameter bit USE_PERES = 1'b0
) (
  input logic [WIDTH-1:0]   a,
  input logic [WIDTH-1:0]   b,
  input logic               cin,
  input logic [WIDTH-1:0]   sum,
  input logic               cout,
  input logic [2*WIDTH-1:0] garb
);
  logic [WIDTH:0]   total;
  logic [WIDTH-1:0] kin;
  assign total = {1'b0, a} + {1'b0, b} + (WIDTH + 1)'(cin);
  assign kin   = a ^ b ^ total[WIDTH-1:0];

  always_comb begin
    AST_SUM_EXACT: assert ({cout, sum} == total); // R1
    AST_A_ECHO: assert (garb[WIDTH-1:0] == a); // R3
    if ((a ^ b) == {WIDTH{1'b1}})
      AST_PROP_CHAIN: assert (cout == cin); // R2
    if (!USE_PERES)
      AST_TOF_ONES: assert (garb[2*WIDTH-1:WIDTH] == {WIDTH{1'b1}}); // R4
    else
      AST_PER_SIDE: assert (garb[2*WIDTH-1:WIDTH] == ((a ^ b) & kin)); // R5
  end
endmodule

bind rev_cla_adder rev_cla_adder_chk #(.WIDTH(WIDTH), .USE_PERES(USE_PERES)) u_chk (
  .a(a_i), .b(b_i), .cin(c_i), .sum(sum_o), .cout(cout_o), .garb(garb_o)
);

// File: tb/rev_cla_adder_tb.sv
module rev_cla_adder_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [15:0] a16 = '0, b16 = '0;
  logic        c16 = 1'b0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic        c4 = 1'b0;

  logic [15:0] s_t, s_p;
  logic        co_t, co_p;
  logic [31:0] g_t, g_p;
  logic [3:0]  s4_t, s4_p;
  logic        co4_t, co4_p;
  logic [7:0]  g4_t, g4_p;

  rev_cla_adder #(.WIDTH(16), .USE_PERES(1'b0)) u_dut (
    .a_i(a16), .b_i(b16), .c_i(c16), .sum_o(s_t), .cout_o(co_t), .garb_o(g_t));
  rev_cla_adder #(.WIDTH(16), .USE_PERES(1'b1)) u_dut_p (
    .a_i(a16), .b_i(b16), .c_i(c16), .sum_o(s_p), .cout_o(co_p), .garb_o(g_p));
  rev_cla_adder #(.WIDTH(4), .USE_PERES(1'b0)) u_dut4t (
    .a_i(a4), .b_i(b4), .c_i(c4), .sum_o(s4_t), .cout_o(co4_t), .garb_o(g4_t));
  rev_cla_adder #(.WIDTH(4), .USE_PERES(1'b1)) u_dut4p (
    .a_i(a4), .b_i(b4), .c_i(c4), .sum_o(s4_p), .cout_o(co4_p), .garb_o(g4_p));

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic check16(input string tag);
    logic [16:0] tot;
    logic [15:0] k;
    tot = {1'b0, a16} + {1'b0, b16} + 17'(c16);
    k = a16 ^ b16 ^ tot[15:0];
    check({tag, " R1 toffoli"}, 64'({co_t, s_t}), 64'(tot));
    check({tag, " R1 peres"}, 64'({co_p, s_p}), 64'(tot));
    check({tag, " R3 toffoli"}, 64'(g_t[15:0]), 64'(a16));
    check({tag, " R3 peres"}, 64'(g_p[15:0]), 64'(a16));
    check({tag, " R4"}, 64'(g_t[31:16]), 64'(16'hFFFF));
    check({tag, " R5"}, 64'(g_p[31:16]), 64'((a16 ^ b16) & k));
  endtask

  initial begin
    // R7: single-slice exhaustive sweep, both gate kinds
    for (int v = 0; v < 512; v++) begin
      @(posedge clk);
      a4 = v[3:0]; b4 = v[7:4]; c4 = v[8];
      @(negedge clk);
      begin
        logic [4:0] tot;
        logic [3:0] k;
        tot = {1'b0, a4} + {1'b0, b4} + 5'(c4);
        k = a4 ^ b4 ^ tot[3:0];
        check("R7 R1 toffoli", 64'({co4_t, s4_t}), 64'(tot));
        check("R7 R1 peres", 64'({co4_p, s4_p}), 64'(tot));
        check("R7 R3", 64'({g4_t[3:0], g4_p[3:0]}), 64'({a4, a4}));
        check("R7 R4", 64'(g4_t[7:4]), 64'(4'hF));
        check("R7 R5", 64'(g4_p[7:4]), 64'((a4 ^ b4) & k));
      end
    end

    // R6: extremes
    @(posedge clk); a16 = '0; b16 = '0; c16 = 1'b0;
    @(negedge clk);
    check("R6 zero sum", 64'({co_t, s_t, co_p, s_p}), 64'(0));
    check16("R6 zero");
    @(posedge clk); a16 = '1; b16 = '1; c16 = 1'b1;
    @(negedge clk);
    check("R6 full toffoli", 64'({co_t, s_t}), 64'(17'h1FFFF));
    check("R6 full peres", 64'({co_p, s_p}), 64'(17'h1FFFF));
    check16("R6 full");

    // R2: every bit propagates
    for (int n = 0; n < 64; n++) begin
      @(posedge clk);
      a16 = 16'($urandom); b16 = ~a16; c16 = n[0];
      @(negedge clk);
      check("R2 cout toffoli", 64'(co_t), 64'(c16));
      check("R2 cout peres", 64'(co_p), 64'(c16));
      check("R2 sum", 64'({s_t, s_p}), c16 ? 64'(0) : 64'(32'hFFFFFFFF));
      check16("R2");
    end

    // R1: random 16-bit vectors
    for (int n = 0; n < 1500; n++) begin
      @(posedge clk);
      a16 = 16'($urandom); b16 = 16'($urandom); c16 = 1'($urandom);
      @(negedge clk);
      check16("rand");
    end

    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 100000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule